// File: doc/BRIEF.md
# Guarded Host Register Access Controller

This block sits between a host's simple synchronous read/write port and the storage behind a multichannel serial controller. That storage has two regions. The first is a small set of host interface registers. The second is a per-group internal configuration RAM, which holds time-slot maps, subchannel maps and channel settings. The block decodes each host access and decides whether the storage may see it. It forwards permitted accesses to a backing port, and each forwarded write carries a per-bit write mask. Accesses that are not permitted never reach the storage, and the host reads back a fixed pattern that tells the kind of denial.

Two conditions decide the rules. The first is whether the transmit and receive line clocks of a channel group are alive. A clock is alive when a synchronized edge has been seen within a programmable timeout. The second is whether any channel on any group is active. While any channel is active, only a small safe set of host registers may be touched. Any other access is blocked and sets a sticky violation flag.

Top module: `hra_guard`

## Requirements
- R1: A read of a valid internal-RAM word whose group does not have both line clocks alive returns 32'hDEADACCE and raises no backing read. Internal RAM is the region where host_addr[11]=1; the group is host_addr[10:9] and the word is host_addr[8:0]; words 0..IRAM_WORDS-1 are valid.
- R2: A write to a valid internal-RAM word whose group does not have both line clocks alive is discarded, and the stored word keeps its value.
- R3: A read returns 32'hFFFFFFFF when the address is invalid or the register is write-only. Invalid addresses are host-region addresses 0x008..0x7FF and internal-RAM words at or above IRAM_WORDS. The only write-only register is 0x005, the message length.
- R4: A write to an invalid address changes nothing. A write to a valid register changes only its writable bits. The writable masks are: 0x000 FFFFFFFF, 0x001 FFFFFFFC, 0x002 0000FFFF, 0x003 00000000 (read-only), 0x004 000000FF, 0x005 00003FFF, 0x006 and 0x007 FFFFFFFF, and every internal-RAM word FFFFFFFF.
- R5: While chan_active is all zero, every valid register and every internal-RAM word of a live group can be read and written.
- R6: While any bit of chan_active is set, only registers 0x001, 0x002, 0x003, 0x006 and 0x007 are accessible, and the rule covers every group. A write to any other location is dropped, and a read of it returns 32'hFFFFFFFF.
- R7: An access blocked under R6 sets access_violation from the next cycle on, and only reset clears the flag.
- R8: A line clock counts as alive while fewer than TIMEOUT system cycles have passed since the last synchronized edge was detected. A clock that has stopped is dead once that window has passed, and it is alive again soon after it restarts.
- R9: host_rvalid is high exactly in the cycle after a read request, carrying host_rdata. A write request produces no host_rvalid.
- R10: bk_we is asserted only for a permitted write whose register has at least one writable bit. bk_re is asserted only for a permitted read of a readable location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address of the access |
| host_wdata | input | 32 | Write data |
| host_rvalid | output | 1 | Read result valid, one cycle after the request |
| host_rdata | output | 32 | Read result |
| access_violation | output | 1 | Sticky flag for an access blocked during active operation |
| tx_lclk | input | NUM_GROUPS | Transmit line clock of each group, asynchronous |
| rx_lclk | input | NUM_GROUPS | Receive line clock of each group, asynchronous |
| chan_active | input | NUM_GROUPS | Per-group flag: at least one channel is active |
| bk_re | output | 1 | Backing storage read enable |
| bk_we | output | 1 | Backing storage write enable |
| bk_addr | output | ADDR_W | Backing storage word address |
| bk_wdata | output | 32 | Backing storage write data |
| bk_wmask | output | 32 | Per-bit write enable for the backing storage |
| bk_rdata | input | 32 | Backing storage read data, valid in the cycle of bk_re |

## Verification
On every cycle, the assertions check the properties that can be read straight off the ports. A read is answered one cycle later, and a write is not answered. The violation flag never falls outside reset. A blocked internal-RAM access raises the flag. No backing enable fires without a matching host request. While a channel is active, a backing enable goes only to the safe register set. Other behaviours depend on the history of stored values and on the timing of the line clocks, so only the bench's scenarios can show them: the exact read-back patterns, the preservation of read-only bits, the discarding of writes to dead groups, and the alive window of a clock that stops and restarts.

// File: rtl/hra_pkg.sv
package hra_pkg;

    localparam int unsigned HRA_DW = 32;

    localparam logic [HRA_DW-1:0] PAT_DEAD = 32'hDEAD_ACCE;
    localparam logic [HRA_DW-1:0] PAT_ONES = '1;

    // result of decoding one host address
    typedef struct packed {
        logic              valid;     // location exists
        logic              readable;  // not write-only
        logic              safe;      // reachable while channels run
        logic              is_iram;   // internal RAM region
        logic [HRA_DW-1:0] wmask;     // writable bits
    } dec_t;

    // registered state of the top level
    typedef struct packed {
        logic              rvalid;
        logic [HRA_DW-1:0] rdata;
        logic              viol;
    } guard_st_t;

    // registered state of one line-clock monitor
    typedef struct packed {
        logic [2:0] sync;
    } sync_st_t;

endpackage

// File: rtl/hra_lclk_monitor.sv
module hra_lclk_monitor #(
    parameter int unsigned TIMEOUT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lclk,
    output logic alive
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT);

    hra_pkg::sync_st_t st_d, st_q;
    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic              edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], lclk};
        edge_seen = st_q.sync[2] ^ st_q.sync[1];
        cnt_d     = cnt_q;
        if (edge_seen) begin
            cnt_d = '0;
        end else if (cnt_q < CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            cnt_q <= CNT_MAX;   // dead until an edge arrives
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign alive = (cnt_q < CNT_MAX);

endmodule

// File: rtl/hra_addr_decode.sv
module hra_addr_decode #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned IRAM_WORDS = 64
) (
    input  logic [ADDR_W-1:0]                     addr,
    output hra_pkg::dec_t                         dec,
    output logic [$clog2(NUM_GROUPS)-1:0]         grp
);
    localparam int unsigned GRP_W  = $clog2(NUM_GROUPS);
    localparam int unsigned OFF_W  = ADDR_W - 1 - GRP_W;
    localparam int unsigned HIDX_W = 3;
    localparam int unsigned HUP_W  = ADDR_W - 1 - HIDX_W;

    logic [OFF_W-1:0]  off;
    logic [HUP_W-1:0]  host_upper;
    logic [HIDX_W-1:0] host_idx;

    assign grp        = addr[ADDR_W-2 -: GRP_W];
    assign off        = addr[OFF_W-1:0];
    assign host_upper = addr[ADDR_W-2:HIDX_W];
    assign host_idx   = addr[HIDX_W-1:0];

    always_comb begin
        dec          = '0;
        dec.is_iram  = addr[ADDR_W-1];
        if (dec.is_iram) begin
            dec.valid    = (32'(off) < IRAM_WORDS);
            dec.readable = dec.valid;
            dec.wmask    = dec.valid ? hra_pkg::PAT_ONES : '0;
        end else if (host_upper == '0) begin
            dec.valid    = 1'b1;
            dec.readable = 1'b1;
            unique case (host_idx)
                3'd0: dec.wmask = 32'hFFFF_FFFF;               // global setup
                3'd1: begin dec.wmask = 32'hFFFF_FFFC; dec.safe = 1'b1; end
                3'd2: begin dec.wmask = 32'h0000_FFFF; dec.safe = 1'b1; end
                3'd3: begin dec.wmask = 32'h0000_0000; dec.safe = 1'b1; end
                3'd4: dec.wmask = 32'h0000_00FF;               // port setup
                3'd5: begin dec.wmask = 32'h0000_3FFF; dec.readable = 1'b0; end
                default: begin dec.wmask = 32'hFFFF_FFFF; dec.safe = 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/hra_guard.sv
module hra_guard #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned IRAM_WORDS = 64,
    parameter int unsigned TIMEOUT    = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_valid,
    input  logic                  host_we,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [31:0]           host_wdata,
    output logic                  host_rvalid,
    output logic [31:0]           host_rdata,
    output logic                  access_violation,
    input  logic [NUM_GROUPS-1:0] tx_lclk,
    input  logic [NUM_GROUPS-1:0] rx_lclk,
    input  logic [NUM_GROUPS-1:0] chan_active,
    output logic                  bk_re,
    output logic                  bk_we,
    output logic [ADDR_W-1:0]     bk_addr,
    output logic [31:0]           bk_wdata,
    output logic [31:0]           bk_wmask,
    input  logic [31:0]           bk_rdata
);
    import hra_pkg::*;

    localparam int unsigned GRP_W = $clog2(NUM_GROUPS);

    logic [NUM_GROUPS-1:0] tx_alive, rx_alive, grp_alive;
    dec_t                  dec;
    logic [GRP_W-1:0]      dec_grp;
    guard_st_t             st_d, st_q;
    logic                  blocked, dead, allow;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mon
        hra_lclk_monitor #(.TIMEOUT(TIMEOUT)) u_tx (
            .clk(clk), .rst_n(rst_n), .lclk(tx_lclk[g]), .alive(tx_alive[g]));
        hra_lclk_monitor #(.TIMEOUT(TIMEOUT)) u_rx (
            .clk(clk), .rst_n(rst_n), .lclk(rx_lclk[g]), .alive(rx_alive[g]));
        assign grp_alive[g] = tx_alive[g] & rx_alive[g];
    end

    hra_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS), .IRAM_WORDS(IRAM_WORDS)
    ) u_dec (
        .addr(host_addr), .dec(dec), .grp(dec_grp)
    );

    always_comb begin
        // denial order: active restriction, invalid, dead line clock
        blocked = host_valid && (|chan_active) && !dec.safe;
        dead    = dec.is_iram && !grp_alive[dec_grp];
        allow   = host_valid && !blocked && dec.valid && !dead;

        bk_addr  = host_addr;
        bk_wdata = host_wdata;
        bk_wmask = dec.wmask;
        bk_re    = allow && !host_we && dec.readable;
        bk_we    = allow && host_we && (|dec.wmask);

        st_d        = st_q;
        st_d.rvalid = host_valid && !host_we;
        st_d.viol   = st_q.viol | blocked;
        if (host_valid && !host_we) begin
            if (blocked || !dec.valid || !dec.readable) begin
                st_d.rdata = PAT_ONES;
            end else if (dead) begin
                st_d.rdata = PAT_DEAD;
            end else begin
                st_d.rdata = bk_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rvalid      = st_q.rvalid;
    assign host_rdata       = st_q.rdata;
    assign access_violation = st_q.viol;

endmodule

// File: rtl/hra_guard_checker.sv
module hra_guard_checker #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned NUM_GROUPS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_valid,
    input logic                  host_we,
    input logic [ADDR_W-1:0]     host_addr,
    input logic [NUM_GROUPS-1:0] chan_active,
    input logic                  host_rvalid,
    input logic                  access_violation,
    input logic                  bk_re,
    input logic                  bk_we
);
    logic safe_loc;
    assign safe_loc = !host_addr[ADDR_W-1] && (host_addr[ADDR_W-2:3] == '0) &&
                      (host_addr[2:0] inside {3'd1, 3'd2, 3'd3, 3'd6, 3'd7});

    p_rvalid_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && !host_we |=> host_rvalid);

    p_no_stray_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && !host_we) |=> !host_rvalid);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        access_violation |=> access_violation);

    p_iram_active_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && (|chan_active) && host_addr[ADDR_W-1] |=> access_violation);

    p_bk_needs_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_we || bk_re) |-> host_valid && (bk_we == host_we) && !(bk_we && bk_re));

    p_active_safe_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_we || bk_re) && (|chan_active) |-> safe_loc);

endmodule

bind hra_guard hra_guard_checker #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
    .host_addr(host_addr), .chan_active(chan_active), .host_rvalid(host_rvalid),
    .access_violation(access_violation), .bk_re(bk_re), .bk_we(bk_we));

// File: tb/hra_guard_bench.sv
module hra_guard_bench;
    localparam int AW = 12;
    localparam int NG = 4;
    localparam int IW = 64;
    localparam int TO = 16;

    logic clk = 0, rst_n = 0;
    logic host_valid = 0, host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic host_rvalid, access_violation, bk_re, bk_we;
    logic [31:0] host_rdata, bk_wdata, bk_wmask, bk_rdata;
    logic [AW-1:0] bk_addr;
    logic [NG-1:0] tx_lclk = '0, rx_lclk = '0, tx_en = '0, rx_en = '0;
    logic [NG-1:0] chan_active = '0;

    int n_cmp = 0, n_bad = 0, we_seen = 0, we_exp = 0;
    logic [31:0] store [0:(1<<AW)-1];
    logic [31:0] ref_m [0:(1<<AW)-1];
    logic [NG-1:0] grp_ok = '0;
    logic exp_viol = 0;
    int div = 0;

    always #2 clk = ~clk;   // 250 MHz

    hra_guard #(.ADDR_W(AW), .NUM_GROUPS(NG), .IRAM_WORDS(IW), .TIMEOUT(TO)) u_hra_guard (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata), .access_violation(access_violation),
        .tx_lclk(tx_lclk), .rx_lclk(rx_lclk), .chan_active(chan_active),
        .bk_re(bk_re), .bk_we(bk_we), .bk_addr(bk_addr), .bk_wdata(bk_wdata),
        .bk_wmask(bk_wmask), .bk_rdata(bk_rdata));

    // backing storage model
    assign bk_rdata = store[bk_addr];
    always @(posedge clk) begin
        if (bk_we) begin
            store[bk_addr] <= (store[bk_addr] & ~bk_wmask) | (bk_wdata & bk_wmask);
            we_seen <= we_seen + 1;
        end
        if (div == 2) begin
            div <= 0;
            tx_lclk <= tx_lclk ^ tx_en;
            rx_lclk <= rx_lclk ^ rx_en;
        end else div <= div + 1;
    end

    initial begin
        #800000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic logic [31:0] mask_of(input logic [AW-1:0] a);
        if (a[AW-1]) return (a[8:0] < IW) ? 32'hFFFFFFFF : 32'h0;
        if (a[AW-2:3] != 0) return 32'h0;
        case (a[2:0])
            3'd1: return 32'hFFFFFFFC;
            3'd2: return 32'h0000FFFF;
            3'd3: return 32'h00000000;
            3'd4: return 32'h000000FF;
            3'd5: return 32'h00003FFF;
            default: return 32'hFFFFFFFF;
        endcase
    endfunction

    function automatic bit valid_of(input logic [AW-1:0] a);
        if (a[AW-1]) return a[8:0] < IW;
        return a[AW-2:3] == 0;
    endfunction

    function automatic bit safe_of(input logic [AW-1:0] a);
        return !a[AW-1] && a[AW-2:3] == 0 && (a[2:0] inside {1, 2, 3, 6, 7});
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        string tag;
        bit blk, dead;
        blk  = (|chan_active) && !safe_of(a);
        dead = a[AW-1] && !grp_ok[a[10:9]];
        exp_rd = 32'hFFFFFFFF;
        if (blk) begin
            tag = "R6"; exp_viol = 1;
        end else if (!valid_of(a)) begin
            tag = we ? "R4" : "R3";
        end else if (!we && !a[AW-1] && a[2:0] == 3'd5) begin
            tag = "R3";
        end else if (dead) begin
            tag = we ? "R2" : "R1"; exp_rd = 32'hDEADACCE;
        end else begin
            tag = "R5"; exp_rd = ref_m[a];
            if (we) begin
                ref_m[a] = (ref_m[a] & ~mask_of(a)) | (d & mask_of(a));
                if (mask_of(a) != 0) we_exp++;
            end
        end
        @(negedge clk);
        host_valid = 1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 0; host_we = 0;
        check("R9 rvalid", {31'b0, host_rvalid}, {31'b0, !we});
        if (!we) check({tag, " rdata"}, host_rdata, exp_rd);
        check("R7 flag", {31'b0, access_violation}, {31'b0, exp_viol});
    endtask

    task automatic rd_chk(input logic [AW-1:0] a); access(0, a, 0); endtask

    function automatic logic [AW-1:0] rnd_addr();
        if ($urandom % 4 == 0) return AW'($urandom % 10);
        return {1'b1, 2'($urandom % 4), 9'($urandom % 70)};
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) begin store[i] = 0; ref_m[i] = 0; end
        repeat (3) @(negedge clk);
        check("R7 reset flag", {31'b0, access_violation}, 0);
        check("R9 reset rvalid", {31'b0, host_rvalid}, 0);
        rst_n = 1;
        // groups 0..2 fully clocked, group 3 has a silent receive clock
        tx_en = 4'b1111; rx_en = 4'b0111;
        repeat (12) @(negedge clk);
        grp_ok = 4'b0111;

        // directed corner cases
        access(1, 12'h003, 32'hFFFFFFFF); rd_chk(12'h003);      // R4 read-only
        access(1, 12'h001, 32'h12345677); rd_chk(12'h001);      // R4 low bits kept
        access(1, 12'h005, 32'hFFFFFFFF); rd_chk(12'h005);      // R3 write-only
        access(1, 12'h010, 32'hA5A5A5A5); rd_chk(12'h010);      // R3/R4 invalid
        access(1, {1'b1, 2'd1, 9'd64}, 32'h1); rd_chk({1'b1, 2'd1, 9'd64});
        access(1, {1'b1, 2'd3, 9'd5}, 32'hCAFE0001);            // R2 dead group
        rd_chk({1'b1, 2'd3, 9'd5});                             // R1
        access(1, {1'b1, 2'd2, 9'd7}, 32'h0BADF00D); rd_chk({1'b1, 2'd2, 9'd7});

        // R8: receive clock of group 3 starts, group 3 becomes usable
        rx_en[3] = 1; repeat (12) @(negedge clk); grp_ok[3] = 1;
        rd_chk({1'b1, 2'd3, 9'd5});                             // R2: old value kept
        access(1, {1'b1, 2'd3, 9'd5}, 32'h600DCAFE); rd_chk({1'b1, 2'd3, 9'd5});
        // R8: stop group 1 transmit clock; still alive briefly, dead after window
        access(1, {1'b1, 2'd1, 9'd9}, 32'h11112222);
        tx_en[1] = 0;
        rd_chk({1'b1, 2'd1, 9'd9});
        repeat (TO + 12) @(negedge clk); grp_ok[1] = 0;
        rd_chk({1'b1, 2'd1, 9'd9});
        tx_en[1] = 1; repeat (12) @(negedge clk); grp_ok[1] = 1;
        rd_chk({1'b1, 2'd1, 9'd9});

        // R5 random idle traffic
        for (int i = 0; i < 300; i++) access(1'($urandom % 2), rnd_addr(), $urandom);

        // R6 global restriction: group 0 active, group 2 map write forbidden
        chan_active = 4'b0001;
        rd_chk(12'h002);                                        // safe, flag stays 0
        access(1, {1'b1, 2'd2, 9'd7}, 32'hFFFFFFFF);            // R6, R7 flag rises
        chan_active = 4'b0000;
        rd_chk({1'b1, 2'd2, 9'd7});                             // R6 unchanged
        chan_active = 4'b1010;
        for (int i = 0; i < 150; i++) access(1'($urandom % 2), rnd_addr(), $urandom);
        chan_active = 4'b0000;
        rd_chk(12'h004);
        check("R7 still set", {31'b0, access_violation}, 1);
        check("R10 write enables", we_seen, we_exp);

        // R7 flag cleared only by reset
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1; exp_viol = 0;
        check("R7 cleared", {31'b0, access_violation}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule